// File: doc/BRIEF.md
# Sequential Turn-Indicator LED Animator

This block sequences ten LED lines and up to two LED-driver enables for an animated vehicle turn indicator. A four-bit Moore state register steps once per tick of an internal period timer. Every output is a pure decode of the present state. A two-bit selector picks one of three animations: a single lamp that moves along the row, only the even-numbered lamps in turn, or a growing run of odd lamps shared between two drivers.

While the indicator input is high, the animation runs. While it is low, the machine parks in its final state, so the lamps show a steady pattern instead of going dark. The step period is a parameter, given in clock cycles; the default is 72 ms at a 1 MHz clock. The chip reset is asynchronous and active low, and its release is synchronised inside the block. A separate synchronous restart input, driven for example from a supply-good monitor, returns the machine to its idle state.

Top module: `tind_animator`

## Requirements
- R1: While reset is held, and in the idle state 0000 that reset leaves, all ten LED lines and both enables are low.
- R2: With the indicator high, each tick moves the state along 0000, 0101, 0110, 0111, 1000, 1001, 1010, 1011, 1100, 1101, 1110, 1111 and then wraps to 0000. An unused state goes to 0000 on the next tick.
- R3: A tick occurs every STEP_CYCLES clock cycles while the indicator is high. The timer is held at zero while the indicator is low or restart is high, so the first step after either condition ends takes a full period. The state holds between ticks.
- R4: One clock edge after the indicator is sampled low, the state is 1111, and it stays there while the indicator remains low.
- R5: In the single-lamp mode (selector code 0), LED line k for k = 1..9 is high only in state k+4, and LED10 (led[9]) is high in states 1110 and 1111. At most one line is high at a time.
- R6: In the single-lamp mode, drv_en[0] is high exactly when some LED line is high, and drv_en[1] is low.
- R7: In the even-lamp mode (selector code 1), LED lines 1, 3, 5, 7 and 9 stay low. The even lines use the single-lamp decode. drv_en[0] is high exactly when an even line is high, and drv_en[1] is low.
- R8: In the two-driver mode (selector code 2), with A..D the state bits from MSB to LSB:
  - LED1 = D(A+B), LED3 = D(A+BC), LED5 = DA, LED7 = DA(BC'+C) and LED9 = DAB.
  - The even lines are high only in state 1111.
  - drv_en[0] = D(A'BC' + AB'C' + BC) and drv_en[1] = D(AB'C + AB).
- R9: In the two-driver mode, the parked state 1111 drives all ten LED lines and both enables high.
- R10: The selector is captured only while restart is high or the indicator is low, and the capture takes effect from the next cycle. Changes while the animation runs are ignored. Code 3 behaves as code 0.
- R11: A high restart on a clock edge sets the state to 0000 and clears the step timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| restart | input | 1 | Synchronous active-high return to idle and timer clear |
| indicator | input | 1 | High: animate; low: park in the steady all-on state |
| mode_sel | input | 2 | Animation select: 0 single lamp, 1 even lamps, 2 two-driver run, 3 as 0 |
| led | output | 10 | LED lines; led[0] is LED1, led[9] is LED10 |
| drv_en | output | 2 | Driver enables; drv_en[1] is used only in the two-driver mode |

## Verification
The outputs decode the state register with no further register, so each result appears on the clock edge that changes the state. A step is due STEP_CYCLES rising edges after restart falls or the indicator rises. The parked pattern and a new selector are due one edge after the input is sampled. The bench drives its inputs and samples outputs on the falling edge, and counts rising edges between stimulus and check. For every step it checks two things: the output still shows the previous state after STEP_CYCLES-1 edges, and it shows the new state after STEP_CYCLES edges.

// File: rtl/tind_pkg.sv
package tind_pkg;

  localparam int LED_N   = 10;
  localparam int EN_N    = 2;
  localparam int STATE_W = 4;

  typedef logic [STATE_W-1:0] tind_state_t;

  typedef enum logic [1:0] {
    ANIM_SINGLE = 2'd0,
    ANIM_EVEN   = 2'd1,
    ANIM_ALT    = 2'd2
  } anim_e;

  localparam tind_state_t ST_IDLE  = 4'b0000;
  localparam tind_state_t ST_FIRST = 4'b0101;
  localparam tind_state_t ST_PARK  = 4'b1111;

  // lamps 2,4,6,8,10 sit at odd bit indices
  localparam logic [LED_N-1:0] EVEN_LAMPS = 10'b10_1010_1010;

endpackage

// File: rtl/tind_rst_sync.sv
module tind_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/tind_tick_gen.sv
module tind_tick_gen #(
  parameter int STEP_CYCLES = 72000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  output logic tick
);

  localparam int CW = (STEP_CYCLES > 1) ? $clog2(STEP_CYCLES) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(STEP_CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          at_last;

  assign at_last = (cnt_q == CNT_LAST);
  assign tick    = run && !clr && at_last;

  always_comb begin
    if (clr || !run)  cnt_d = '0;
    else if (at_last) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/tind_seq_core.sv
module tind_seq_core
  import tind_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        restart,
  input  logic        indicator,
  input  logic        tick,
  input  logic [1:0]  mode_sel,
  output tind_state_t state,
  output anim_e       mode
);

  tind_state_t state_q, state_d, step_nxt;
  anim_e       mode_q, mode_d;
  logic        state_en, mode_en;

  // successor along the animation ring
  always_comb begin
    if (state_q == ST_IDLE)                               step_nxt = ST_FIRST;
    else if (state_q == ST_PARK)                          step_nxt = ST_IDLE;
    else if (state_q >= ST_FIRST && state_q < ST_PARK)    step_nxt = state_q + 1'b1;
    else                                                  step_nxt = ST_IDLE;
  end

  assign state_en = restart || !indicator || tick;
  assign mode_en  = restart || !indicator;

  always_comb begin
    if (restart)         state_d = ST_IDLE;
    else if (!indicator) state_d = ST_PARK;
    else                 state_d = step_nxt;
  end

  always_comb begin
    if (mode_sel == 2'd3) mode_d = ANIM_SINGLE;
    else                  mode_d = anim_e'(mode_sel);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      mode_q  <= ANIM_SINGLE;
    end else begin
      if (state_en) state_q <= state_d;
      if (mode_en)  mode_q  <= mode_d;
    end
  end

  assign state = state_q;
  assign mode  = mode_q;

endmodule

// File: rtl/tind_out_dec.sv
module tind_out_dec
  import tind_pkg::*;
(
  input  tind_state_t     state,
  input  anim_e           mode,
  output logic [LED_N-1:0] led,
  output logic [EN_N-1:0]  drv_en
);

  logic a, b, c, d;
  logic [LED_N-1:0] run_map;   // single-lamp decode
  logic [LED_N-1:0] alt_map;   // two-driver decode
  logic             alt_en0, alt_en1;

  assign {a, b, c, d} = state;

  for (genvar k = 0; k < LED_N - 1; k++) begin : g_run
    assign run_map[k] = (state == STATE_W'(k + 5));
  end
  assign run_map[LED_N-1] = a & b & c;

  for (genvar k = 1; k < LED_N; k += 2) begin : g_alt_even
    assign alt_map[k] = a & b & c & d;
  end
  assign alt_map[0] = d & (a | b);
  assign alt_map[2] = d & (a | (b & c));
  assign alt_map[4] = d & a;
  assign alt_map[6] = d & a & ((b & ~c) | c);
  assign alt_map[8] = d & a & b;

  assign alt_en0 = d & ((~a & b & ~c) | (a & ~b & ~c) | (b & c));
  assign alt_en1 = d & ((a & ~b & c) | (a & b));

  always_comb begin
    unique case (mode)
      ANIM_EVEN: begin
        led    = run_map & EVEN_LAMPS;
        drv_en = {1'b0, |(run_map & EVEN_LAMPS)};
      end
      ANIM_ALT: begin
        led    = alt_map;
        drv_en = {alt_en1, alt_en0};
      end
      default: begin
        led    = run_map;
        drv_en = {1'b0, |run_map};
      end
    endcase
  end

endmodule

// File: rtl/tind_animator.sv
module tind_animator
  import tind_pkg::*;
#(
  parameter int STEP_CYCLES = 72000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             indicator,
  input  logic [1:0]       mode_sel,
  output logic [LED_N-1:0] led,
  output logic [EN_N-1:0]  drv_en
);

  logic        rst_sync_n;
  logic        tick;
  tind_state_t state;
  anim_e       mode;

  tind_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  tind_tick_gen #(.STEP_CYCLES(STEP_CYCLES)) u_tick (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .clr   (restart),
    .run   (indicator),
    .tick  (tick)
  );

  tind_seq_core u_core (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .restart   (restart),
    .indicator (indicator),
    .tick      (tick),
    .mode_sel  (mode_sel),
    .state     (state),
    .mode      (mode)
  );

  tind_out_dec u_dec (
    .state  (state),
    .mode   (mode),
    .led    (led),
    .drv_en (drv_en)
  );

endmodule

// File: rtl/tind_animator_chk.sv
module tind_animator_chk (
  input logic       clk,
  input logic       rst_sync_n,
  input logic       restart,
  input logic       indicator,
  input logic       tick,
  input logic [3:0] state,
  input logic [1:0] mode,
  input logic [9:0] led,
  input logic [1:0] drv_en
);

  a_r2_wrap_to_idle: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!restart && indicator && tick && state == 4'hF) |=> (state == 4'h0));

  a_r3_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!restart && indicator && !tick) |=> $stable(state));

  a_r4_park_on_low: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!restart && !indicator) |=> (state == 4'hF));

  a_r5_single_onehot: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mode == 2'd0) |-> $onehot0(led));

  a_r6_en_follows_lamps: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mode == 2'd0) |-> (drv_en[0] == (|led) && !drv_en[1]));

  a_r7_odd_lamps_dark: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mode == 2'd1) |-> ((led & 10'h155) == 10'h000));

  a_r8_second_driver_lamp7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mode == 2'd2) |-> (drv_en[1] == led[6]));

  a_r8_first_driver_lamp1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mode == 2'd2 && drv_en[0]) |-> led[0]);

  a_r10_mode_frozen: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!restart && indicator) |=> $stable(mode));

  a_r11_restart_idle: assert property (@(posedge clk) disable iff (!rst_sync_n)
    restart |=> (state == 4'h0));

endmodule

bind tind_animator tind_animator_chk u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .restart    (restart),
  .indicator  (indicator),
  .tick       (tick),
  .state      (state),
  .mode       (mode),
  .led        (led),
  .drv_en     (drv_en)
);

// File: tb/tind_animator_test.sv
module tind_animator_test;

  localparam int CLK_PERIOD = 10;
  localparam int STEP       = 4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       restart;
  logic       indicator;
  logic [1:0] mode_sel;
  logic [9:0] led;
  logic [1:0] drv_en;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tind_animator #(.STEP_CYCLES(STEP)) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (restart),
    .indicator (indicator),
    .mode_sel  (mode_sel),
    .led       (led),
    .drv_en    (drv_en)
  );

  // expected {drv_en, led} for a mode and state, from the requirements
  function automatic logic [11:0] exp_vec(input int m, input logic [3:0] st);
    logic [9:0] l;
    logic [1:0] e;
    l = '0;
    e = '0;
    if (m == 2) begin
      case (st)
        4'd5:  begin l = 10'h001; e = 2'b01; end
        4'd7:  begin l = 10'h005; e = 2'b01; end
        4'd9:  begin l = 10'h015; e = 2'b01; end
        4'd11: begin l = 10'h055; e = 2'b10; end
        4'd13: begin l = 10'h155; e = 2'b10; end
        4'd15: begin l = 10'h3FF; e = 2'b11; end
        default: ;
      endcase
    end else begin
      if (st >= 4'd5 && st <= 4'd13) l[int'(st) - 5] = 1'b1;
      if (st >= 4'd14) l[9] = 1'b1;
      if (m == 1) l = l & 10'h2AA;
      e = {1'b0, |l};
    end
    return {e, l};
  endfunction

  function automatic logic [3:0] nxt(input logic [3:0] s);
    if (s == 4'd0)  return 4'd5;
    if (s == 4'd15) return 4'd0;
    return s + 4'd1;
  endfunction

  task automatic check(input string req, input logic [11:0] exp);
    n_chk++;
    if ({drv_en, led} !== exp) begin
      n_fail++;
      $display("FAIL %s: got %03h expected %03h at %0t", req, {drv_en, led}, exp, $time);
    end
  endtask

  // restart with indicator high, leaving the machine idle with the given selector
  task automatic go_idle(input logic [1:0] m);
    @(negedge clk);
    mode_sel  = m;
    indicator = 1'b1;
    restart   = 1'b1;
    @(posedge clk);
    @(negedge clk);
    restart = 1'b0;
  endtask

  task automatic step_once;
    repeat (STEP) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; restart = 1'b0; indicator = 1'b0; mode_sel = 2'd0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 in reset", 12'h000);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
  endtask

  task automatic t_full_run(input int m, input string req);
    logic [3:0] cur;
    go_idle(2'(m));
    cur = 4'd0;
    check("R1 idle", exp_vec(m, cur));
    for (int i = 0; i < 12; i++) begin
      repeat (STEP - 1) @(posedge clk);
      @(negedge clk);
      check("R3 hold before tick", exp_vec(m, cur));
      @(posedge clk);
      @(negedge clk);
      cur = nxt(cur);
      check(req, exp_vec(m, cur));
    end
  endtask

  task automatic t_drop(input int m, input string req);
    go_idle(2'(m));
    repeat (3) step_once();          // state 0111
    indicator = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check(req, exp_vec(m, 4'd15));
    repeat (5) @(posedge clk);
    @(negedge clk);
    check("R4 stays parked", exp_vec(m, 4'd15));
    indicator = 1'b1;
    repeat (STEP - 1) @(posedge clk);
    @(negedge clk);
    check("R3 full first period", exp_vec(m, 4'd15));
    @(posedge clk);
    @(negedge clk);
    check("R2 wrap after park", exp_vec(m, 4'd0));
  endtask

  task automatic t_mode_freeze;
    go_idle(2'd0);
    mode_sel = 2'd2;                 // ignored while animating
    step_once();
    step_once();                     // state 0110
    check("R10 selector ignored", exp_vec(0, 4'd6));
    indicator = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R10 captured while low (R9)", 12'hFFF);
  endtask

  task automatic t_mode3;
    go_idle(2'd3);
    step_once();
    step_once();
    check("R10 code 3 as single", exp_vec(0, 4'd6));
  endtask

  task automatic t_restart_mid;
    go_idle(2'd0);
    step_once();
    step_once();                     // state 0110
    repeat (2) @(posedge clk);       // timer part-way
    @(negedge clk);
    restart = 1'b1;
    @(posedge clk);
    @(negedge clk);
    restart = 1'b0;
    check("R11 restart to idle", exp_vec(0, 4'd0));
    repeat (STEP - 1) @(posedge clk);
    @(negedge clk);
    check("R11 timer cleared", exp_vec(0, 4'd0));
    @(posedge clk);
    @(negedge clk);
    check("R11 first step", exp_vec(0, 4'd5));
  endtask

  initial begin
    t_reset();
    t_full_run(0, "R5/R6 single sequence R2");
    t_full_run(1, "R7 even sequence");
    t_full_run(2, "R8 two-driver sequence");
    t_drop(0, "R4 parked single");
    t_drop(1, "R4 parked even");
    t_drop(2, "R9 parked all on");
    t_mode_freeze();
    t_mode3();
    t_restart_mid();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

endmodule